// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Show-Ahead Read

This block is a synchronous first-in-first-out buffer whose write and read sides share one clock. Words enter on the write stream and leave on the read stream. Occupancy is reported as a word count, as full and empty flags, and as two early-warning flags whose thresholds are parameters. The storage is a register array that sits inside the block.

A parameter selects one of two read styles. In the registered style, a word reaches the output only in the cycle after a read is accepted. In the show-ahead style, the oldest stored word is always visible on the output while the buffer holds data, and an accepted read moves the output on to the next word. Two further parameters turn the guard against writing into a full buffer, and the guard against reading from an empty one, on or off. Both guards are on by default.

Back-pressure on the write stream works like this. `wr_valid` offers `wr_data`, and the word is taken on the rising edge whenever `full` is low. On the read stream, `rd_ready` requests a word, and the request is honoured whenever `empty` is low. An asynchronous clear and a synchronous clear both return the buffer to its empty state.

Top module: `sfifo_showahead`

## Requirements
- R1: With RD_MODE = RD_NORMAL, a read accepted at a clock edge places the oldest stored word on `rd_data` after that edge. `rd_data` keeps its value in every cycle in which no read is accepted.
- R2: With RD_MODE = RD_SHOWAHEAD, `rd_data` equals the oldest stored word whenever `empty` is 0, with no read request needed. A read accepted at an edge makes `rd_data` show the next word after that edge.
- R3: With OVF_CHECK = 1, a write offered while `full` is 1 is dropped. The count does not change because of it, and no stored word is altered.
- R4: With UNF_CHECK = 1, a read requested while `empty` is 1 is dropped. The count stays 0, and a registered-mode `rd_data` keeps its value.
- R5: `level` rises by 1 after an accepted write alone, falls by 1 after an accepted read alone, and stays the same when a write and a read are both accepted at the same edge.
- R6: `full` is 1 exactly when the count equals DEPTH. `empty` is 1 exactly when the count is 0.
- R7: `almost_full` is 1 exactly when the count is greater than or equal to AF_LEVEL.
- R8: `almost_empty` is 1 exactly when the count is strictly less than AE_LEVEL.
- R9: While `arst` is 1, with no clock edge needed, the block reports empty=1, full=0, level=0 and almost_empty=1 (for AE_LEVEL > 0). A registered-mode `rd_data` reads 0.
- R10: `srst` high at a clock edge gives the same cleared state as R9 after that edge, whatever the request inputs are doing. Neither clear has a minimum length.
- R11: Words leave in the order they were written, including when the storage index wraps past DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| arst | input | 1 | Asynchronous clear, active high |
| srst | input | 1 | Synchronous clear, active high |
| wr_valid | input | 1 | Write offer; taken when `full` is 0 |
| wr_data | input | DATA_W | Word to store |
| rd_ready | input | 1 | Read request; honoured when `empty` is 0 |
| rd_data | output | DATA_W | Output word (registered or show-ahead, per RD_MODE) |
| full | output | 1 | Count equals DEPTH |
| empty | output | 1 | Count is zero |
| almost_full | output | 1 | Count >= AF_LEVEL |
| almost_empty | output | 1 | Count < AE_LEVEL |
| level | output | CNT_W | Stored word count, modulo 2^CNT_W |

## Verification
The embedded properties assume that every input is synchronous to `clk` and stable around its rising edge. They also assume that `arst` is released away from an edge and that both guards are enabled, so that an accepted read never meets an empty buffer. The stimulus changes the request and data inputs only at the falling edge. It raises `arst` part of the way through a cycle and drops it at a falling edge. It keeps the default guard settings, so that requests made against a full or empty buffer exercise the dropping path and do not break the properties' premises.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic {
    RD_NORMAL   = 1'b0,
    RD_SHOWAHEAD = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
  parameter int DEPTH     = 8,
  parameter int CNT_W     = 4,
  parameter bit OVF_CHECK = 1'b1,
  parameter bit UNF_CHECK = 1'b1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          srst,
  input  logic          wr_valid,
  input  logic          rd_ready,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CNT_W:0] cnt,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0]  LAST = AW'(DEPTH - 1);
  localparam logic [CNT_W:0] FULLC = (CNT_W + 1)'(DEPTH);

  assign full  = (cnt == FULLC);
  assign empty = (cnt == '0);

  // Guards: each side is gated only when its protection is enabled.
  assign wr_en = wr_valid & (~full  | ~OVF_CHECK);
  assign rd_en = rd_ready & (~empty | ~UNF_CHECK);

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (srst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  generate
    if (OVF_CHECK) begin : g_ovf_chk
      assert_no_overflow_R3: assert property (@(posedge clk) disable iff (arst)
        (full && wr_valid && !rd_ready && !srst) |=> full && (cnt == $past(cnt)));
    end
    if (UNF_CHECK) begin : g_unf_chk
      assert_no_underflow_R4: assert property (@(posedge clk) disable iff (arst)
        (empty && rd_ready && !wr_valid) |=> empty);
    end
  endgenerate

  assert_write_step_R5: assert property (@(posedge clk) disable iff (arst)
    (wr_valid && !full && !rd_ready && !srst) |=> cnt == $past(cnt) + 1'b1);

  assert_both_hold_R5: assert property (@(posedge clk) disable iff (arst)
    (wr_valid && rd_ready && !full && !empty && !srst) |=> $stable(cnt));

  assert_flag_excl_R6: assert property (@(posedge clk) disable iff (arst)
    !(full && empty));

  assert_sync_clear_R10: assert property (@(posedge clk) disable iff (arst)
    srst |=> empty && (wr_ptr == rd_ptr));
endmodule

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (we && (waddr == AW'(i))) store[i] <= wdata;
      end
    end
  endgenerate

  assign rdata = store[raddr];
endmodule

// File: rtl/sfifo_rdstage.sv
module sfifo_rdstage
  import sfifo_pkg::*;
#(
  parameter int       DATA_W  = 8,
  parameter rd_mode_e RD_MODE = RD_NORMAL
) (
  input  logic              clk,
  input  logic              arst,
  input  logic              srst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] head,
  output logic [DATA_W-1:0] q
);
  generate
    if (RD_MODE == RD_SHOWAHEAD) begin : g_show
      // Oldest word is visible straight from the array.
      assign q = head;
      assert_head_hold_R2: assert property (@(posedge clk) disable iff (arst)
        (!rd_en && !wr_en && !srst) |=> $stable(q));
    end else begin : g_norm
      logic [DATA_W-1:0] q_r;
      always_ff @(posedge clk or posedge arst) begin
        if (arst)       q_r <= '0;
        else if (srst)  q_r <= '0;
        else if (rd_en) q_r <= head;
      end
      assign q = q_r;
      assert_q_hold_R1: assert property (@(posedge clk) disable iff (arst)
        (!rd_en && !wr_en && !srst) |=> $stable(q));
    end
  endgenerate
endmodule

// File: rtl/sfifo_showahead.sv
module sfifo_showahead
  import sfifo_pkg::*;
#(
  parameter int       DATA_W    = 8,
  parameter int       DEPTH     = 8,
  parameter int       CNT_W     = 4,
  parameter int       AF_LEVEL  = 6,
  parameter int       AE_LEVEL  = 2,
  parameter rd_mode_e RD_MODE   = RD_NORMAL,
  parameter bit       OVF_CHECK = 1'b1,
  parameter bit       UNF_CHECK = 1'b1
) (
  input  logic              clk,
  input  logic              arst,
  input  logic              srst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic              almost_full,
  output logic              almost_empty,
  output logic [CNT_W-1:0]  level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  generate
    if (DEPTH < 4 || DEPTH > (1 << CNT_W)) begin : g_bad_cfg
      $error("sfifo_showahead: DEPTH must be >= 4 and <= 2**CNT_W");
    end
  endgenerate

  logic          wr_en, rd_en;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CNT_W:0] cnt;
  logic [DATA_W-1:0] head;

  sfifo_ctrl #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .OVF_CHECK(OVF_CHECK), .UNF_CHECK(UNF_CHECK)
  ) u_ctrl (
    .clk(clk), .arst(arst), .srst(srst),
    .wr_valid(wr_valid), .rd_ready(rd_ready),
    .wr_en(wr_en), .rd_en(rd_en),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .cnt(cnt), .full(full), .empty(empty)
  );

  sfifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .rdata(head)
  );

  sfifo_rdstage #(.DATA_W(DATA_W), .RD_MODE(RD_MODE)) u_rd (
    .clk(clk), .arst(arst), .srst(srst),
    .rd_en(rd_en), .wr_en(wr_en), .head(head), .q(rd_data)
  );

  assign almost_full  = (cnt >= (CNT_W + 1)'(AF_LEVEL));
  assign almost_empty = (cnt <  (CNT_W + 1)'(AE_LEVEL));
  assign level        = cnt[CNT_W-1:0];

  generate
    if (AF_LEVEL <= DEPTH) begin : g_af_chk
      assert_af_covers_full_R7: assert property (@(posedge clk) disable iff (arst)
        full |-> almost_full);
    end
    if (AE_LEVEL > 0) begin : g_ae_chk
      assert_ae_covers_empty_R8: assert property (@(posedge clk) disable iff (arst)
        empty |-> almost_empty);
    end
  endgenerate
endmodule

// File: tb/tb_sfifo_showahead.sv
module tb_sfifo_showahead;
  import sfifo_pkg::*;

  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int CW = 4;
  localparam int AF = 6;
  localparam int AE = 2;

  logic clk = 1'b0;
  logic arst = 1'b1;
  logic srst = 1'b0;
  logic wr_valid = 1'b0;
  logic rd_ready = 1'b0;
  logic [DW-1:0] wr_data = '0;

  logic [DW-1:0] q_n, q_s;
  logic full_n, empty_n, af_n, ae_n;
  logic full_s, empty_s, af_s, ae_s;
  logic [CW-1:0] lvl_n, lvl_s;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] mq[$];
  logic [DW-1:0] exp_q = '0;

  always #4 clk = ~clk;

  sfifo_showahead #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW), .AF_LEVEL(AF),
    .AE_LEVEL(AE), .RD_MODE(RD_NORMAL)) dut (
    .clk(clk), .arst(arst), .srst(srst), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_ready(rd_ready), .rd_data(q_n), .full(full_n), .empty(empty_n),
    .almost_full(af_n), .almost_empty(ae_n), .level(lvl_n));

  sfifo_showahead #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW), .AF_LEVEL(AF),
    .AE_LEVEL(AE), .RD_MODE(RD_SHOWAHEAD)) dut_sa (
    .clk(clk), .arst(arst), .srst(srst), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_ready(rd_ready), .rd_data(q_s), .full(full_s), .empty(empty_s),
    .almost_full(af_s), .almost_empty(ae_s), .level(lvl_s));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_state(input string ctx);
    int n = mq.size();
    chk({ctx, " R5 level"}, int'(lvl_n), n);
    chk({ctx, " R5 level show-ahead"}, int'(lvl_s), n);
    chk({ctx, " R6 full"}, int'(full_n), int'(n == DEPTH));
    chk({ctx, " R6 empty"}, int'(empty_n), int'(n == 0));
    chk({ctx, " R6 empty show-ahead"}, int'(empty_s), int'(n == 0));
    chk({ctx, " R7 almost_full"}, int'(af_n), int'(n >= AF));
    chk({ctx, " R8 almost_empty"}, int'(ae_n), int'(n < AE));
    chk({ctx, " R1 registered q"}, int'(q_n), int'(exp_q));
    if (n > 0) chk({ctx, " R2 R11 show-ahead head"}, int'(q_s), int'(mq[0]));
  endtask

  // Called at a falling edge; applies one cycle of stimulus and checks after the next rising edge.
  task automatic step(input bit wv, input logic [DW-1:0] wd, input bit rr, input bit sc,
                      input string ctx);
    bit wa, ra;
    wr_valid = wv; wr_data = wd; rd_ready = rr; srst = sc;
    if (sc) begin
      mq.delete();
      exp_q = '0;
    end else begin
      wa = wv && (mq.size() < DEPTH);
      ra = rr && (mq.size() > 0);
      if (ra) exp_q = mq.pop_front();
      if (wa) mq.push_back(wd);
    end
    @(posedge clk);
    @(negedge clk);
    check_state(ctx);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0] dv = 8'h10;
    repeat (3) @(negedge clk);
    // R9: cleared state while asynchronous clear is held
    check_state("reset");
    chk("R9 ae in reset", int'(ae_n), 1);
    arst = 1'b0;
    @(negedge clk);
    check_state("post-reset");

    // Fill past full: R3 drops
    for (int i = 0; i < DEPTH + 3; i++) begin
      step(1'b1, dv, 1'b0, 1'b0, "fill R3");
      dv = dv + 8'd7;
    end
    chk("R3 full held", int'(full_n), 1);
    // Write plus read while full: write dropped, read taken
    step(1'b1, 8'hEE, 1'b1, 1'b0, "full rw R3");
    // Drain past empty: R4 drops
    for (int i = 0; i < DEPTH + 3; i++) step(1'b0, 8'h00, 1'b1, 1'b0, "drain R4");
    chk("R4 empty held", int'(empty_n), 1);
    // Write and read together while empty: only write taken
    step(1'b1, 8'h5A, 1'b1, 1'b0, "empty rw R4");
    step(1'b0, 8'h00, 1'b0, 1'b0, "idle R1");

    // Near-exhaustive pseudo-random sweep in three biases (R5, R11 wrap)
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < 1500; i++) begin
        bit wv, rr;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ph)
          0: begin wv = (lfsr[1:0] != 2'b00); rr = (lfsr[3:2] == 2'b00); end
          1: begin wv = (lfsr[1:0] == 2'b00); rr = (lfsr[3:2] != 2'b00); end
          default: begin wv = lfsr[0]; rr = lfsr[5]; end
        endcase
        step(wv, lfsr[15:8], rr, 1'b0, "sweep R11");
      end
    end

    // Simultaneous traffic at a mid level keeps level (R5)
    while (mq.size() < 4) step(1'b1, dv++, 1'b0, 1'b0, "mid fill R5");
    while (mq.size() > 4) step(1'b0, 8'h00, 1'b1, 1'b0, "mid drain R5");
    for (int i = 0; i < 20; i++) step(1'b1, dv++, 1'b1, 1'b0, "both R5");
    chk("R5 level held at 4", int'(lvl_n), 4);

    // Synchronous clear overrides requests (R10)
    step(1'b1, 8'h99, 1'b1, 1'b1, "sclr R10");
    chk("R10 empty after sclr", int'(empty_n), 1);
    step(1'b1, 8'h31, 1'b0, 1'b0, "after sclr R10");
    step(1'b1, 8'h32, 1'b1, 1'b0, "after sclr R10");

    // Asynchronous clear mid-cycle with no edge (R9)
    for (int i = 0; i < 5; i++) step(1'b1, dv++, 1'b0, 1'b0, "pre-aclr");
    step(1'b0, 8'h00, 1'b1, 1'b0, "pre-aclr read");
    wr_valid = 1'b0; rd_ready = 1'b0;
    #1 arst = 1'b1;
    #1;
    mq.delete();
    exp_q = '0;
    check_state("aclr R9");
    @(negedge clk);
    arst = 1'b0;
    step(1'b1, 8'h44, 1'b0, 1'b0, "after aclr R9");
    step(1'b0, 8'h00, 1'b1, 1'b0, "after aclr R1");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule